// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register numbers held in the pipeline registers and decides two things. First, it picks the source of each execute-stage ALU operand: the register file, the result waiting in the memory-stage register, or the result waiting in the writeback-stage register. Second, it finds a load whose destination is needed by the instruction now in decode. In that case it holds the program counter and the fetch/decode register for a cycle, and it clears the control fields that enter the execute stage.

All outputs are combinational functions of the current register numbers, except for one flag register. That flag remembers that a bubble was inserted in the previous cycle, so each load-use hazard costs exactly one stall cycle. After that cycle the loaded value reaches the execute stage through the writeback bypass. Branch resolution and flushing are handled elsewhere.

Top module: `fwd_hazard_unit`

## Requirements
- R1: `fwd_a` is 2'b10 when `exmem_wr` is 1, `exmem_rd` is nonzero and `exmem_rd` equals `idex_rs`.
- R2: `fwd_b` is 2'b10 when `exmem_wr` is 1, `exmem_rd` is nonzero and `exmem_rd` equals `idex_rt`.
- R3: For either operand, the select is 2'b01 when `memwb_wr` is 1, `memwb_rd` is nonzero and `memwb_rd` equals that operand's source register, and the R1/R2 condition for that operand does not hold.
- R4: When both the memory-stage and the writeback-stage conditions hold for one operand, the newer memory-stage result wins and the select is 2'b10.
- R5: A destination register number of zero never produces a bypass, whatever the write-enable bits are.
- R6: When no bypass condition holds, the select is 2'b00 (register file). The value 2'b11 never appears.
- R7: A load-use hazard exists when `idex_memrd` is 1 and `idex_rt` equals `ifid_rs` or `ifid_rt`. In a stall cycle, `pc_we` and `ifid_we` are 0 and `idex_zero` is 1.
- R8: With no load-use hazard, `pc_we` and `ifid_we` are 1 and `idex_zero` is 0.
- R9: The cycle after a stall cycle never stalls, even if the hazard condition is still present. A hazard that persists into a third cycle stalls again.
- R10: Reset (`rst_n` low, asynchronous) clears the bubble flag. During and after reset, a present hazard stalls at once.
- R11: The bypass selects do not depend on the stall state. They keep their values during stall cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_rs | input | AW | First source register of the instruction in decode |
| ifid_rt | input | AW | Second source register of the instruction in decode |
| idex_rs | input | AW | First source register of the instruction in execute |
| idex_rt | input | AW | Second source register (load destination) in execute |
| idex_memrd | input | 1 | Instruction in execute reads data memory |
| exmem_rd | input | AW | Destination register in the memory stage |
| exmem_wr | input | 1 | Memory-stage instruction writes a register |
| memwb_rd | input | AW | Destination register in the writeback stage |
| memwb_wr | input | 1 | Writeback-stage instruction writes a register |
| fwd_a | output | 2 | Operand A source: 00 register file, 01 writeback, 10 memory stage |
| fwd_b | output | 2 | Operand B source, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_zero | output | 1 | Clear the control fields entering execute |

## Verification
The bench sweeps every mix of write enables and of destination and source numbers drawn from registers 0 to 3. This covers the double-write case where both later stages target the same register. A design with the wrong priority would hand the execute stage the stale writeback value there. A design missing the zero guard would bypass a result meant for the hard-wired zero register.

The load-use sweep holds each pattern for three cycles. A design without the bubble flag would stall forever on a held hazard. A design with a flag that never clears would miss the repeated stall. A reset applied while the flag is set checks that the flag is cleared.

// File: rtl/fh_pkg.sv
package fh_pkg;
  typedef enum logic [1:0] {
    FWD_REGFILE  = 2'b00,
    FWD_FROM_WB  = 2'b01,
    FWD_FROM_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPERANDS = 2;
endpackage

// File: rtl/fh_bypass_pick.sv
module fh_bypass_pick
  import fh_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_reg,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_wr,
  input  logic [AW-1:0] wb_rd,
  output fwd_sel_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  // a producer qualifies only if it writes a real (nonzero) register
  assign mem_hit = mem_wr && (mem_rd != ZERO_REG) && (mem_rd == src_reg);
  assign wb_hit  = wb_wr  && (wb_rd  != ZERO_REG) && (wb_rd  == src_reg);

  // newest producer first
  always_comb begin
    if (mem_hit)     sel = FWD_FROM_MEM;
    else if (wb_hit) sel = FWD_FROM_WB;
    else             sel = FWD_REGFILE;
  end
endmodule

// File: rtl/fh_loaduse_det.sv
module fh_loaduse_det #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic [AW-1:0] ex_load_dst,
  input  logic          ex_is_load,
  output logic          hit
);
  assign hit = ex_is_load && ((ex_load_dst == dec_rs) || (ex_load_dst == dec_rt));
endmodule

// File: rtl/fh_bubble_ctl.sv
module fh_bubble_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hazard,
  output logic stall
);
  logic bubble_q;
  logic bubble_d;

  always_comb begin
    stall    = hazard && !bubble_q;
    bubble_d = stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bubble_q <= 1'b0;
    else        bubble_q <= bubble_d;
  end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fh_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  input  logic [AW-1:0] idex_rs,
  input  logic [AW-1:0] idex_rt,
  input  logic          idex_memrd,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_wr,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_zero
);
  logic [AW-1:0] op_src [NUM_OPERANDS];
  fwd_sel_e      op_sel [NUM_OPERANDS];
  logic          lu_hit;
  logic          stall;

  assign op_src[0] = idex_rs;
  assign op_src[1] = idex_rt;

  for (genvar gi = 0; gi < NUM_OPERANDS; gi++) begin : g_operand
    fh_bypass_pick #(.AW(AW)) u_pick (
      .src_reg (op_src[gi]),
      .mem_wr  (exmem_wr),
      .mem_rd  (exmem_rd),
      .wb_wr   (memwb_wr),
      .wb_rd   (memwb_rd),
      .sel     (op_sel[gi])
    );
  end

  fh_loaduse_det #(.AW(AW)) u_det (
    .dec_rs      (ifid_rs),
    .dec_rt      (ifid_rt),
    .ex_load_dst (idex_rt),
    .ex_is_load  (idex_memrd),
    .hit         (lu_hit)
  );

  fh_bubble_ctl u_bubble (
    .clk    (clk),
    .rst_n  (rst_n),
    .hazard (lu_hit),
    .stall  (stall)
  );

  assign fwd_a     = op_sel[0];
  assign fwd_b     = op_sel[1];
  assign pc_we     = !stall;
  assign ifid_we   = !stall;
  assign idex_zero = stall;
endmodule

// File: rtl/fh_unit_checks.sv
module fh_unit_checks #(
  parameter int unsigned AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ifid_rs,
  input logic [AW-1:0] ifid_rt,
  input logic [AW-1:0] idex_rs,
  input logic [AW-1:0] idex_rt,
  input logic          idex_memrd,
  input logic [AW-1:0] exmem_rd,
  input logic          exmem_wr,
  input logic [AW-1:0] memwb_rd,
  input logic          memwb_wr,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_zero
);
  AST_MEM_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_wr && exmem_rd != '0 && exmem_rd == idex_rs) |-> fwd_a == 2'b10); // R1
  AST_MEM_BYPASS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_wr && exmem_rd != '0 && exmem_rd == idex_rt) |-> fwd_b == 2'b10); // R2
  AST_WB_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (memwb_wr && memwb_rd != '0 && memwb_rd == idex_rs &&
     !(exmem_wr && exmem_rd != '0 && exmem_rd == idex_rs)) |-> fwd_a == 2'b01); // R3
  AST_NEWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b == 2'b01) |-> !(exmem_wr && exmem_rd == idex_rt && exmem_rd != '0)); // R4
  AST_ZERO_NEVER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b10) |-> exmem_rd != '0); // R5
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a != 2'b11 && fwd_b != 2'b11); // R6
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    idex_zero |-> (!pc_we && !ifid_we && idex_memrd)); // R7
  AST_NO_HAZARD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_memrd |-> (pc_we && ifid_we && !idex_zero)); // R8
  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    idex_zero |=> !idex_zero); // R9
endmodule

bind fwd_hazard_unit fh_unit_checks #(.AW(AW)) u_checks (.*);

// File: tb/fwd_hazard_unit_test.sv
`timescale 1ns/1ps
module fwd_hazard_unit_test;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd;
  logic          idex_memrd, exmem_wr, memwb_wr;
  logic [1:0]    fwd_a, fwd_b;
  logic          pc_we, ifid_we, idex_zero;

  int checks = 0;
  int errors = 0;
  bit model_flag;

  always #10 clk = ~clk;

  fwd_hazard_unit #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
    .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_memrd(idex_memrd),
    .exmem_rd(exmem_rd), .exmem_wr(exmem_wr),
    .memwb_rd(memwb_rd), .memwb_wr(memwb_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_zero(idex_zero)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_sel(input bit ew, input int erd, input bit ww,
                                 input int wrd, input int src);
    bit eh = ew && erd != 0 && erd == src;
    bit wh = ww && wrd != 0 && wrd == src;
    return eh ? 2 : (wh ? 1 : 0);
  endfunction

  function automatic string tag_for(input bit ew, input int erd, input bit ww,
                                    input int wrd, input int src, input bit op_a);
    bit eh = ew && erd != 0 && erd == src;
    bit wh = ww && wrd != 0 && wrd == src;
    if (eh && wh) return "R4";
    if (eh) return op_a ? "R1" : "R2";
    if (wh) return "R3";
    if ((ew && erd == src) || (ww && wrd == src)) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ifid_rs = '0; ifid_rt = '0; idex_rs = '0; idex_rt = '0;
    exmem_rd = '0; memwb_rd = '0;
    idex_memrd = 1'b0; exmem_wr = 1'b0; memwb_wr = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    // R10 reset state: running, no bypass
    chk("R10", {pc_we, ifid_we, idex_zero}, 3'b110);
    chk("R6", {fwd_a, fwd_b}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // forwarding sweep over registers 0..3, no load in execute
    for (int ew = 0; ew < 2; ew++)
      for (int ww = 0; ww < 2; ww++)
        for (int erd = 0; erd < 4; erd++)
          for (int wrd = 0; wrd < 4; wrd++)
            for (int rs = 0; rs < 4; rs++)
              for (int rt = 0; rt < 4; rt++) begin
                @(negedge clk);
                exmem_wr = ew[0]; memwb_wr = ww[0];
                exmem_rd = AW'(erd); memwb_rd = AW'(wrd);
                idex_rs = AW'(rs); idex_rt = AW'(rt);
                #5;
                chk(tag_for(ew[0], erd, ww[0], wrd, rs, 1'b1), fwd_a,
                    exp_sel(ew[0], erd, ww[0], wrd, rs));
                chk(tag_for(ew[0], erd, ww[0], wrd, rt, 1'b0), fwd_b,
                    exp_sel(ew[0], erd, ww[0], wrd, rt));
                if (rs == 0 && rt == 0)
                  chk("R8", {pc_we, ifid_we, idex_zero}, 3'b110);
              end

    // load-use sweep; operand A held on a memory-stage bypass
    model_flag = 1'b0;
    for (int ml = 0; ml < 2; ml++)
      for (int lrt = 0; lrt < 4; lrt++)
        for (int drs = 0; drs < 4; drs++)
          for (int drt = 0; drt < 4; drt++)
            for (int rep = 0; rep < 3; rep++) begin
              bit hz, es;
              @(negedge clk);
              idex_memrd = ml[0]; idex_rt = AW'(lrt);
              ifid_rs = AW'(drs); ifid_rt = AW'(drt);
              exmem_wr = 1'b1; exmem_rd = AW'(1); idex_rs = AW'(1);
              memwb_wr = 1'b0;
              #5;
              hz = ml[0] && (lrt == drs || lrt == drt);
              es = hz && !model_flag;
              chk(es ? "R7" : (hz ? "R9" : "R8"),
                  {pc_we, ifid_we, idex_zero}, es ? 3'b001 : 3'b110);
              chk("R11", fwd_a, 2'b10);
              @(posedge clk);
              model_flag = es;
            end

    // R10: reset while the bubble flag is set
    @(negedge clk);
    idex_memrd = 1'b1; idex_rt = AW'(2); ifid_rs = AW'(2); ifid_rt = AW'(3);
    #5;
    chk("R7", {pc_we, ifid_we, idex_zero}, model_flag ? 3'b110 : 3'b001);
    @(negedge clk);
    #5;
    chk("R9", {pc_we, ifid_we, idex_zero}, model_flag ? 3'b001 : 3'b110);
    @(negedge clk);
    if (!model_flag) @(negedge clk);
    rst_n = 1'b0;
    #5;
    chk("R10", {pc_we, ifid_we, idex_zero}, 3'b001);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R10", {pc_we, ifid_we, idex_zero}, 3'b001);
    @(negedge clk);
    #5;
    chk("R9", {pc_we, ifid_we, idex_zero}, 3'b110);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule